// File: doc/BRIEF.md
# Letterbox Black Line Detector

This block watches the luma samples of each video field and measures the black bars that a letterboxed picture leaves above and below the image. Every line is given one verdict, black or not black, from its brightest active sample, compared against a blanking level plus a small programmable margin. At each field boundary, three counts are latched. The first is the run of black lines at the top of the field. The second is the run of black lines that closes the evaluated part of the field. The third is the height of a bright band, such as a subtitle, found inside the lower bar.

The host drives the sample stream with a line-valid qualifier and pulses a field-start marker before the first line and a field-end marker after the last one. A 4-bit setting removes a number of final lines from the bottom evaluation, so that the tail of the field can be left out. The three counts stay unchanged for a whole field, so a reader always sees a set that belongs together. Configuration is expected to stay fixed while a field is in progress. The markers must not fall in the same cycle as a line's closing cycle.

Top module: `lbx_detector`

## Requirements
- R1: A line is black exactly when its peak luma is strictly below cfg_blank_level + 4 × cfg_black_thr, with the sum computed without overflow. A peak equal to that limit is not black.
- R2: A line is one unbroken run of cycles with pix_valid high. It is closed on the first cycle with pix_valid low, and its peak is the maximum over all of its samples, wherever in the line the maximum falls.
- R3: top_lines holds the number of consecutive black lines from the first line after field_start. Counting stops at the first non-black line.
- R4: Let S be cfg_tail_skip. The last S lines of the field are excluded from bottom evaluation. bottom_lines holds the length of the black run that ends at the last evaluated line, and is 0 when that line is non-black or when the field has S lines or fewer.
- R5: mid_lines holds the length of the non-black band when the evaluated lines end in this pattern: at least two black lines, then one or more non-black lines, then one or more black lines. In every other case it is 0, and it is never nonzero while bottom_lines is 0.
- R6: All three counts saturate at 255 and never wrap.
- R7: All outputs are 0 after reset. They change only in the cycle after a field_end pulse and hold their value at all other times.
- R8: A field_start pulse discards every line received before it, including the lines of a field that had started but had not ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | High while active luma samples of a line are present |
| pix_luma | input | 8 | Luma sample |
| field_start | input | 1 | One-cycle pulse before the first line of a field |
| field_end | input | 1 | One-cycle pulse after the last line of a field |
| cfg_blank_level | input | 8 | Luma code of the blanking level |
| cfg_black_thr | input | 5 | Black margin in steps of 4 codes |
| cfg_tail_skip | input | 4 | Number of final field lines left out of the bottom evaluation |
| top_lines | output | 8 | Latched top black-line count |
| bottom_lines | output | 8 | Latched bottom black-line count |
| mid_lines | output | 8 | Latched height of the non-black band inside the lower bar |

## Verification
The hardest state to reach is a recognised band whose boundaries sit exactly at the edge of the evaluated region. This happens when the skipped tail cuts into the closing black run, or when the black run above the band is only one line long. The stimulus builds each field from runs of random type and length, so that short black, bright, black endings occur often. Directed fields pin down the single-line preceding run, a band longer than 255 lines, a skip value larger than the field, and peaks one code on either side of the limit.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

  // Black test: peak strictly below blanking level plus scaled margin.
  function automatic logic blk_test(input int unsigned peak,
                                    input int unsigned level,
                                    input int unsigned thr,
                                    input int unsigned step);
    return peak < (level + step * thr);
  endfunction

  // Saturating increment toward lim.
  function automatic int unsigned sat_add1(input int unsigned v,
                                           input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/lbx_line_peak.sv
module lbx_line_peak #(
  parameter int LUMA_W = 8,
  parameter int THR_W  = 5,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [LUMA_W-1:0] pix_luma,
  input  logic [LUMA_W-1:0] level,
  input  logic [THR_W-1:0]  thr,
  output logic              line_done,
  output logic              line_black
);
  import lbx_pkg::*;

  logic              in_line_q;
  logic [LUMA_W-1:0] peak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      peak_q    <= '0;
    end else begin
      in_line_q <= pix_valid;
      if (pix_valid)
        peak_q <= (!in_line_q || pix_luma > peak_q) ? pix_luma : peak_q;
    end
  end

  assign line_done  = in_line_q & ~pix_valid;
  assign line_black = blk_test(32'(peak_q), 32'(level), 32'(thr), STEP);

  // R1: the running peak never falls below the sample just taken
  p_peak_covers_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> peak_q >= $past(pix_luma));

  // R2: a line closes in a single cycle
  p_line_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

endmodule

// File: rtl/lbx_tail_tracker.sv
module lbx_tail_tracker #(
  parameter int CNT_W  = 8,
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              line_done,
  input  logic              line_black,
  input  logic [SKIP_W-1:0] skip,
  output logic [CNT_W-1:0]  bot_cnt,
  output logic [CNT_W-1:0]  mid_cnt
);
  import lbx_pkg::*;

  localparam int DEPTH = 2 ** SKIP_W;
  localparam int CMAX  = 2 ** CNT_W - 1;

  logic [DEPTH-1:0]  hist_q, hist_n;
  logic [SKIP_W:0]   seen_q, seen_n;
  logic [CNT_W-1:0]  run_blk_q, run_nb_q, prev_blk_q, band_q;
  logic              band_ok_q;
  logic              feed, fed_blk;

  always_comb begin
    hist_n  = {hist_q[DEPTH-2:0], line_black};
    seen_n  = (seen_q == (SKIP_W+1)'(DEPTH)) ? seen_q : seen_q + 1'b1;
    feed    = line_done && (seen_n > {1'b0, skip});
    fed_blk = hist_n[skip];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0; seen_q <= '0; run_blk_q <= '0; run_nb_q <= '0;
      prev_blk_q <= '0; band_q <= '0; band_ok_q <= 1'b0;
    end else if (clear) begin
      hist_q <= '0; seen_q <= '0; run_blk_q <= '0; run_nb_q <= '0;
      prev_blk_q <= '0; band_q <= '0; band_ok_q <= 1'b0;
    end else if (line_done) begin
      hist_q <= hist_n;
      seen_q <= seen_n;
      if (feed) begin
        if (fed_blk) begin
          if (run_blk_q == '0) begin
            band_ok_q <= (run_nb_q != '0) && (prev_blk_q >= CNT_W'(2));
            band_q    <= run_nb_q;
            run_nb_q  <= '0;
          end
          run_blk_q <= CNT_W'(sat_add1(32'(run_blk_q), CMAX));
        end else begin
          if (run_nb_q == '0) prev_blk_q <= run_blk_q;
          run_nb_q  <= CNT_W'(sat_add1(32'(run_nb_q), CMAX));
          run_blk_q <= '0;
          band_ok_q <= 1'b0;
        end
      end
    end
  end

  assign bot_cnt = run_blk_q;
  assign mid_cnt = band_ok_q ? band_q : '0;

  // R4: a trailing black run and a trailing bright run never coexist
  p_runs_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_blk_q != '0) |-> (run_nb_q == '0));

  // R5: a recognised band is always closed by black lines
  p_band_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    band_ok_q |-> (run_blk_q != '0));

  // R6: bottom run holds at its ceiling
  p_bot_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_blk_q == CNT_W'(CMAX) && !clear && !(feed && !fed_blk))
      |=> run_blk_q == CNT_W'(CMAX));

endmodule

// File: rtl/lbx_detector.sv
module lbx_detector #(
  parameter int LUMA_W = 8,
  parameter int THR_W  = 5,
  parameter int SKIP_W = 4,
  parameter int CNT_W  = 8,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [LUMA_W-1:0] pix_luma,
  input  logic              field_start,
  input  logic              field_end,
  input  logic [LUMA_W-1:0] cfg_blank_level,
  input  logic [THR_W-1:0]  cfg_black_thr,
  input  logic [SKIP_W-1:0] cfg_tail_skip,
  output logic [CNT_W-1:0]  top_lines,
  output logic [CNT_W-1:0]  bottom_lines,
  output logic [CNT_W-1:0]  mid_lines
);
  import lbx_pkg::*;

  localparam int CMAX = 2 ** CNT_W - 1;

  logic             line_done, line_black;
  logic [CNT_W-1:0] bot_cnt, mid_cnt;
  logic [CNT_W-1:0] top_cnt_q;
  logic             top_open_q;

  lbx_line_peak #(.LUMA_W(LUMA_W), .THR_W(THR_W), .STEP(STEP)) u_peak (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_luma(pix_luma),
    .level(cfg_blank_level), .thr(cfg_black_thr),
    .line_done(line_done), .line_black(line_black));

  lbx_tail_tracker #(.CNT_W(CNT_W), .SKIP_W(SKIP_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .clear(field_start),
    .line_done(line_done), .line_black(line_black), .skip(cfg_tail_skip),
    .bot_cnt(bot_cnt), .mid_cnt(mid_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_cnt_q  <= '0;
      top_open_q <= 1'b0;
    end else if (field_start) begin
      top_cnt_q  <= '0;
      top_open_q <= 1'b1;
    end else if (line_done && top_open_q) begin
      if (line_black) top_cnt_q <= CNT_W'(sat_add1(32'(top_cnt_q), CMAX));
      else            top_open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_lines    <= '0;
      bottom_lines <= '0;
      mid_lines    <= '0;
    end else if (field_end) begin
      top_lines    <= top_cnt_q;
      bottom_lines <= bot_cnt;
      mid_lines    <= mid_cnt;
    end
  end

  // R7: results move only after a field boundary
  p_outputs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable({top_lines, bottom_lines, mid_lines}));

  // R6: top counter sticks at its ceiling within a field
  p_top_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (top_cnt_q == CNT_W'(CMAX) && !field_start) |=> top_cnt_q == CNT_W'(CMAX));

  // R5: a band count is never reported without a closing black run
  p_mid_needs_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_lines != '0) |-> (bottom_lines != '0));

  // R8: a new field starts with an empty top count
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> top_cnt_q == '0);

endmodule

// File: tb/lbx_detector_test.sv
module lbx_detector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_luma = '0;
  logic       field_start = 1'b0;
  logic       field_end = 1'b0;
  logic [7:0] cfg_blank_level = 8'd32;
  logic [4:0] cfg_black_thr = 5'd5;
  logic [3:0] cfg_tail_skip = 4'd0;
  logic [7:0] top_lines, bottom_lines, mid_lines;

  int n_checks = 0;
  int n_fail   = 0;
  int peaks [0:399];
  int nlines;

  always #2 clk = ~clk;

  lbx_detector uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_luma(pix_luma),
    .field_start(field_start), .field_end(field_end),
    .cfg_blank_level(cfg_blank_level), .cfg_black_thr(cfg_black_thr),
    .cfg_tail_skip(cfg_tail_skip),
    .top_lines(top_lines), .bottom_lines(bottom_lines), .mid_lines(mid_lines));

  function automatic int lim();
    return int'(cfg_blank_level) + 4 * int'(cfg_black_thr);
  endfunction

  function automatic bit is_blk(int i);
    return peaks[i] < lim();
  endfunction

  function automatic int cap(int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int exp_top();
    int c = 0;
    for (int i = 0; i < nlines; i++) begin
      if (!is_blk(i)) break;
      c++;
    end
    return cap(c);
  endfunction

  function automatic int eval_len();
    return (nlines > int'(cfg_tail_skip)) ? nlines - int'(cfg_tail_skip) : 0;
  endfunction

  function automatic int exp_bot();
    int c = 0;
    for (int i = eval_len() - 1; i >= 0; i--) begin
      if (!is_blk(i)) break;
      c++;
    end
    return cap(c);
  endfunction

  function automatic int exp_mid();
    int i = eval_len() - 1;
    int b = 0, nb = 0, p = 0;
    while (i >= 0 && is_blk(i))  begin b++;  i--; end
    while (i >= 0 && !is_blk(i)) begin nb++; i--; end
    while (i >= 0 && is_blk(i))  begin p++;  i--; end
    return (b > 0 && nb > 0 && p >= 2) ? cap(nb) : 0;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic drive_line(int pk);
    int len = 1 + int'($urandom % 4);
    int pos = int'($urandom % len);
    for (int s = 0; s < len; s++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_luma  = (s == pos) ? 8'(pk) : 8'($urandom % (pk + 1));
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_luma  = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); field_start = 1'b1;
    @(negedge clk); field_start = 1'b0;
  endtask

  task automatic send_lines();
    for (int i = 0; i < nlines; i++) drive_line(peaks[i]);
  endtask

  task automatic finish_field(string tag);
    @(negedge clk); field_end = 1'b1;
    @(negedge clk); field_end = 1'b0;
    check(tag, "top R3", int'(top_lines), exp_top());
    check(tag, "bottom R4", int'(bottom_lines), exp_bot());
    check(tag, "mid R5", int'(mid_lines), exp_mid());
  endtask

  task automatic run_field(string tag);
    pulse_start();
    send_lines();
    finish_field(tag);
  endtask

  function automatic int blk_val();
    return int'($urandom % lim());
  endfunction

  function automatic int pic_val();
    return lim() + int'($urandom % (256 - lim()));
  endfunction

  task automatic set_pattern(string pat);
    nlines = pat.len();
    for (int i = 0; i < nlines; i++)
      peaks[i] = (pat[i] == "B") ? blk_val() : pic_val();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "reset top", int'(top_lines), 0);
    check("R7", "reset bottom", int'(bottom_lines), 0);
    check("R7", "reset mid", int'(mid_lines), 0);
    rst_n = 1'b1;

    // R1: peak one below the limit is black, at the limit is not
    cfg_blank_level = 8'd32; cfg_black_thr = 5'd5; cfg_tail_skip = 4'd0;
    nlines = 3; peaks[0] = 51; peaks[1] = 51; peaks[2] = 52;
    run_field("R1");
    check("R1", "boundary top", int'(top_lines), 2);
    // R1: no overflow of level plus margin
    cfg_blank_level = 8'd250; cfg_black_thr = 5'd31;
    nlines = 2; peaks[0] = 255; peaks[1] = 255;
    run_field("R1");
    check("R1", "wide limit top", int'(top_lines), 2);

    // R5: subtitle band inside the lower bar, tail skipped
    cfg_blank_level = 8'd16; cfg_black_thr = 5'd4; cfg_tail_skip = 4'd2;
    set_pattern("PPPPPBBBBPPPBBBPP");
    run_field("R5");
    check("R5", "band height", int'(mid_lines), 3);
    check("R4", "closing run", int'(bottom_lines), 3);

    // R5: preceding black run of one line gives no band
    cfg_tail_skip = 4'd0;
    set_pattern("PBPPBB");
    run_field("R5");
    check("R5", "short lead run", int'(mid_lines), 0);

    // R6: long black field saturates top and bottom
    nlines = 300;
    for (int i = 0; i < 300; i++) peaks[i] = blk_val();
    run_field("R6");
    check("R6", "top sat", int'(top_lines), 255);
    check("R6", "bottom sat", int'(bottom_lines), 255);

    // R6: band longer than the counter range
    nlines = 303; peaks[0] = blk_val(); peaks[1] = blk_val();
    for (int i = 2; i < 302; i++) peaks[i] = pic_val();
    peaks[302] = blk_val();
    run_field("R6");
    check("R6", "band sat", int'(mid_lines), 255);

    // R4: skip larger than field
    cfg_tail_skip = 4'd15;
    set_pattern("BBBBBBBBBB");
    run_field("R4");
    check("R4", "all skipped", int'(bottom_lines), 0);
    check("R3", "top unaffected by skip", int'(top_lines), 10);

    // R7: lines outside a field leave the results untouched
    set_pattern("PPP");
    send_lines();
    repeat (3) @(negedge clk);
    check("R7", "hold top", int'(top_lines), 10);
    check("R7", "hold bottom", int'(bottom_lines), 0);

    // R8: restart inside a field drops earlier lines
    cfg_tail_skip = 4'd0;
    pulse_start();
    set_pattern("PPP");
    send_lines();
    set_pattern("BBBB");
    run_field("R8");
    check("R8", "restart top", int'(top_lines), 4);

    // R2 + all: random fields built from runs
    for (int f = 0; f < 60; f++) begin
      int n, k;
      cfg_blank_level = 8'(16 + $urandom % 48);
      cfg_black_thr   = 5'($urandom % 32);
      cfg_tail_skip   = 4'($urandom % 16);
      n = 1 + int'($urandom % 40);
      k = 0;
      while (k < n) begin
        bit blk = 1'($urandom % 2);
        int rl = 1 + int'($urandom % 5);
        for (int j = 0; j < rl && k < n; j++) begin
          peaks[k] = blk ? blk_val() : pic_val();
          k++;
        end
      end
      nlines = n;
      run_field("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule